// File: doc/BRIEF.md
# Interrupt-Driven Event Sequencer

This block takes the place of a general-purpose processor for the routine work of a low-power sensor node. It waits with nothing active until a device raises an interrupt line. It then reads that line's service-routine start address from a table in shared memory and fetches short programs from the same memory. It executes them one instruction at a time. A program can power devices up or down, copy words from one device to another over a single-master address/data bus, read or write a single bus word, write an immediate control word to a device, jump, and terminate.

There is no arithmetic unit and no register file. The only data state is one holding word, which carries a value from a bus read to a later bus write. Control runs through four states: idle, vector lookup, fetch and execute. Each program returns the block to idle with a terminate instruction. Interrupts that arrive while a program runs are remembered. They are served in priority order once the block is idle again.

Top module: `evt_seq`

## Requirements
- R1: During and after reset, `pwr_en` is all zero, `bus_req` is low and no memory read is issued until an interrupt line rises.
- R2: When an interrupt is taken in idle, the block reads memory address `VEC_BASE + line` (default base 0). It then fetches its first instruction from the address held in that word.
- R3: If several lines are pending, the lowest index is served first. A line pulsed while a program runs is latched and served after the running program terminates.
- R4: The instruction word carries its opcode in bits [15:13]. Opcode 0 sets and opcode 1 clears `pwr_en[d]`, where d is taken from instruction bits [2:0]. No other power bit changes.
- R5: Opcode 2 (jump) takes one operand word and continues fetching at that address. Instructions placed between the jump and its target have no effect.
- R6: Opcode 3 (terminate) returns the block to idle. No further memory read happens until the next interrupt.
- R7: Opcode 4 reads the bus address given in its operand into the holding word. Opcode 5 writes the holding word to the bus address given in its operand.
- R8: Opcode 6 takes a data word and then an address word, and issues one bus write of that data to that address.
- R9: Opcode 7 takes a count, a source address and a destination address. It issues count pairs of accesses, each a read of the source followed by a write of the value read to the destination. Both addresses stay fixed. A count of 0 causes no bus access.
- R10: While `bus_req` is high and `bus_ready` is low, `bus_addr`, `bus_we` and `bus_wdata` hold their values. An access completes at the clock edge where both are high.
- R11: Memory read data is taken one cycle after `mem_rd_en`. At most one memory read is issued per two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | N_IRQ | Interrupt request lines, one per device |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Memory read data, valid one cycle after the strobe |
| bus_req | output | 1 | System bus access request |
| bus_we | output | 1 | Bus direction, 1 = write |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data, sampled when ready is high |
| bus_ready | input | 1 | Bus access completion |
| pwr_en | output | N_DEV | Per-device power enables |

## Verification
The bench uses the default parameters: eight interrupt lines, eight power enables, and 16-bit addresses and data. With these values every priority position can be driven, including simultaneous requests on the lowest and highest lines. Power switching is exercised on device 0 and device 7, the two ends of the enable vector. The 16-bit words let the bench place the vector table, eight programs and distinct device addresses in one small memory. Bus waits of zero and three cycles show that held requests and transfer alternation survive stalls.

// File: rtl/evt_seq.sv
module evt_seq #(
  parameter int N_IRQ    = 8,
  parameter int N_DEV    = 8,
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int VEC_BASE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_rdata,
  output logic             bus_req,
  output logic             bus_we,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_ready,
  output logic [N_DEV-1:0] pwr_en
);
  localparam int IW  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
  localparam int DVW = (N_DEV > 1) ? $clog2(N_DEV) : 1;

  typedef enum logic [1:0] {ST_READY, ST_LOOKUP, ST_FETCH, ST_EXEC} st_t;
  typedef enum logic [2:0] {
    OP_ON, OP_OFF, OP_JMP, OP_END, OP_RD, OP_WR, OP_WRI, OP_XFR
  } op_t;

  st_t             state;
  logic            ph;
  logic [N_IRQ-1:0] pend;
  logic [IW-1:0]   line;
  logic [AW-1:0]   pc;
  op_t             op;
  logic [DVW-1:0]  dev;
  logic [DW-1:0]   opa, opb, opc, xcnt, hold;
  logic [1:0]      fcnt;

  logic [N_IRQ-1:0] req_all, take;
  logic [IW-1:0]   pick;
  op_t             cur_op;
  logic            bus_done;

  function automatic logic [1:0] n_opnd(input op_t o);
    case (o)
      OP_JMP, OP_RD, OP_WR: n_opnd = 2'd1;
      OP_WRI:               n_opnd = 2'd2;
      OP_XFR:               n_opnd = 2'd3;
      default:              n_opnd = 2'd0;
    endcase
  endfunction

  assign req_all = pend | irq;

  always_comb begin
    pick = '0;
    for (int i = N_IRQ - 1; i >= 0; i--)
      if (req_all[i]) pick = IW'(i);
  end

  assign take   = (state == ST_READY && |req_all) ? (N_IRQ'(1) << pick) : '0;
  assign cur_op = (fcnt == 2'd0) ? op_t'(mem_rdata[DW-1:DW-3]) : op;

  assign mem_rd_en = (state == ST_LOOKUP || state == ST_FETCH) && !ph;
  assign mem_addr  = (state == ST_LOOKUP) ? AW'(VEC_BASE) + AW'(line) : pc;

  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    if (state == ST_EXEC) begin
      case (op)
        OP_RD:  begin bus_req = 1'b1; bus_addr = AW'(opa); end
        OP_WR:  begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(opa); bus_wdata = hold; end
        OP_WRI: begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(opb); bus_wdata = opa; end
        OP_XFR: begin
          bus_req   = (xcnt != '0);
          bus_we    = ph;
          bus_addr  = ph ? AW'(opc) : AW'(opb);
          bus_wdata = hold;
        end
        default: ;
      endcase
    end
  end

  assign bus_done = bus_req && bus_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_READY;
      ph     <= 1'b0;
      pend   <= '0;
      line   <= '0;
      pc     <= '0;
      op     <= OP_END;
      dev    <= '0;
      opa    <= '0;
      opb    <= '0;
      opc    <= '0;
      xcnt   <= '0;
      hold   <= '0;
      fcnt   <= '0;
      pwr_en <= '0;
    end else begin
      pend <= req_all & ~take;
      case (state)
        ST_READY: if (|req_all) begin
          line  <= pick;
          ph    <= 1'b0;
          state <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          ph <= ~ph;
          if (ph) begin
            pc    <= AW'(mem_rdata);
            fcnt  <= '0;
            state <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          ph <= ~ph;
          if (ph) begin
            case (fcnt)
              2'd0: begin op <= cur_op; dev <= mem_rdata[DVW-1:0]; end
              2'd1: begin opa <= mem_rdata; xcnt <= mem_rdata; end
              2'd2: opb <= mem_rdata;
              default: opc <= mem_rdata;
            endcase
            pc <= pc + 1'b1;
            if (fcnt == n_opnd(cur_op)) begin
              fcnt  <= '0;
              state <= ST_EXEC;
            end else begin
              fcnt <= fcnt + 1'b1;
            end
          end
        end
        ST_EXEC: begin
          case (op)
            OP_ON:  begin if (32'(dev) < N_DEV) pwr_en[dev] <= 1'b1; state <= ST_FETCH; end
            OP_OFF: begin if (32'(dev) < N_DEV) pwr_en[dev] <= 1'b0; state <= ST_FETCH; end
            OP_JMP: begin pc <= AW'(opa); state <= ST_FETCH; end
            OP_END: state <= ST_READY;
            OP_RD:  if (bus_done) begin hold <= bus_rdata; state <= ST_FETCH; end
            OP_WR, OP_WRI: if (bus_done) state <= ST_FETCH;
            default: begin
              if (xcnt == '0) begin
                ph    <= 1'b0;
                state <= ST_FETCH;
              end else if (bus_done) begin
                if (!ph) begin
                  hold <= bus_rdata;
                  ph   <= 1'b1;
                end else begin
                  ph   <= 1'b0;
                  xcnt <= xcnt - 1'b1;
                  if (xcnt == DW'(1)) state <= ST_FETCH;
                end
              end
            end
          endcase
        end
        default: state <= ST_READY;
      endcase
    end
  end

  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  assert_pwr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pwr_en ^ $past(pwr_en)) <= 1);

  assert_pwr_from_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en != $past(pwr_en)) |-> ($past(state) == ST_EXEC));

  assert_lookup_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOOKUP) |=> (state == ST_LOOKUP || state == ST_FETCH));

  assert_xfer_alternate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && op == OP_XFR && bus_done && !bus_we) |=> (bus_req && bus_we));

  assert_mem_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  assert_idle_no_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_EXEC && $past(op) == OP_END) |-> !bus_req);
endmodule

// File: tb/tb_evt_seq.sv
`timescale 1ns/1ps
module tb_evt_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq = '0;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        bus_req, bus_we;
  logic [15:0] bus_addr, bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_ready = 1'b0;
  logic [7:0]  pwr_en;

  evt_seq dut (
    .clk(clk), .rst_n(rst_n), .irq(irq),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .pwr_en(pwr_en)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  logic [15:0] mem [0:127];
  int          mrd_n = 0;
  logic [15:0] mrd_addr [0:63];

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= mem[mem_addr[6:0]];
      if (mrd_n < 64) mrd_addr[mrd_n] = mem_addr;
      mrd_n = mrd_n + 1;
    end
  end

  int          slv_wait = 0;
  int          wcnt = 0;
  int          nwr = 0;
  int          nrd = 0;
  logic [15:0] wr_addr [0:15];
  logic [15:0] wr_data [0:15];

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ready = 1'b0;
      wcnt = 0;
    end else if (bus_ready) begin
      bus_ready = 1'b0;
      wcnt = 0;
    end else if (bus_req) begin
      if (wcnt >= slv_wait) begin
        bus_ready = 1'b1;
        if (bus_we) begin
          if (nwr < 16) begin
            wr_addr[nwr] = bus_addr;
            wr_data[nwr] = bus_wdata;
          end
          nwr = nwr + 1;
        end else begin
          bus_rdata = bus_addr ^ 16'h5A00;
          nrd = nrd + 1;
        end
      end else begin
        wcnt = wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic clear_logs();
    nwr = 0;
    nrd = 0;
    mrd_n = 0;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk) irq = m;
    @(negedge clk) irq = '0;
  endtask

  typedef struct packed {
    logic [7:0]  irqm;
    logic [7:0]  nw;
    logic [7:0]  nr;
    logic [15:0] fa;
    logic [15:0] fd;
    logic [15:0] la;
    logic [15:0] ld;
    logic [7:0]  pwr;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{8'h01, 8'd1, 8'd0, 16'h0040, 16'hA5A5, 16'h0040, 16'hA5A5, 8'h04},
    '{8'h02, 8'd3, 8'd3, 16'h0200, 16'h5B00, 16'h0200, 16'h5B00, 8'h00},
    '{8'h04, 8'd1, 8'd1, 16'h0301, 16'h5900, 16'h0301, 16'h5900, 8'h00},
    '{8'h08, 8'd1, 8'd0, 16'h0051, 16'h1234, 16'h0051, 16'h1234, 8'h00},
    '{8'h10, 8'd0, 8'd0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'h00},
    '{8'h20, 8'd0, 8'd0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'h01},
    '{8'hC0, 8'd2, 8'd0, 16'h0066, 16'h0006, 16'h0077, 16'h0007, 8'h01},
    '{8'h81, 8'd2, 8'd0, 16'h0040, 16'hA5A5, 16'h0077, 16'h0007, 8'h05}
  };

  function automatic string vtag(input int i);
    case (i)
      0: return "R4 R8 on+immediate";
      1: return "R9 transfer";
      2: return "R7 read/write";
      3: return "R5 jump";
      4: return "R9 zero-count";
      5: return "R4 device ends";
      6: return "R3 priority";
      default: return "R3 R4 R8 mixed";
    endcase
  endfunction

  task automatic load_mem();
    for (int i = 0; i < 128; i++) mem[i] = 16'h6000;
    mem[0] = 16; mem[1] = 24; mem[2] = 32; mem[3] = 40;
    mem[4] = 50; mem[5] = 56; mem[6] = 64; mem[7] = 70;
    mem[16] = 16'h0002; mem[17] = 16'hC000; mem[18] = 16'hA5A5; mem[19] = 16'h0040; mem[20] = 16'h6000;
    mem[24] = 16'hE000; mem[25] = 16'd3; mem[26] = 16'h0100; mem[27] = 16'h0200; mem[28] = 16'h2002; mem[29] = 16'h6000;
    mem[32] = 16'h8000; mem[33] = 16'h0300; mem[34] = 16'hA000; mem[35] = 16'h0301; mem[36] = 16'h6000;
    mem[40] = 16'h4000; mem[41] = 16'd45; mem[42] = 16'hC000; mem[43] = 16'hDEAD; mem[44] = 16'h0050;
    mem[45] = 16'hC000; mem[46] = 16'h1234; mem[47] = 16'h0051; mem[48] = 16'h6000;
    mem[50] = 16'hE000; mem[51] = 16'd0; mem[52] = 16'h0700; mem[53] = 16'h0701; mem[54] = 16'h6000;
    mem[56] = 16'h0007; mem[57] = 16'h0000; mem[58] = 16'h2007; mem[59] = 16'h6000;
    mem[64] = 16'hC000; mem[65] = 16'h0006; mem[66] = 16'h0066; mem[67] = 16'h6000;
    mem[70] = 16'hC000; mem[71] = 16'h0007; mem[72] = 16'h0077; mem[73] = 16'h6000;
  endtask

  task automatic idle_check(input string what);
    int snap;
    snap = mrd_n;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(mrd_n == snap && !bus_req, what, 32'(mrd_n), 32'(snap));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    load_mem();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pwr_en == 8'h00, "R1 reset power", 32'(pwr_en), 0);
    chk(!bus_req && !mem_rd_en, "R1 reset quiet", {30'd0, bus_req, mem_rd_en}, 0);
    rst_n = 1'b1;
    clear_logs();
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(mrd_n == 0 && !bus_req, "R1 idle without interrupt", 32'(mrd_n), 0);

    for (int v = 0; v < 8; v++) begin
      clear_logs();
      pulse(VT[v].irqm);
      repeat (260) @(posedge clk);
      @(negedge clk);
      chk(nwr == int'(VT[v].nw), {vtag(v), " write count"}, 32'(nwr), 32'(VT[v].nw));
      chk(nrd == int'(VT[v].nr), {vtag(v), " read count"}, 32'(nrd), 32'(VT[v].nr));
      if (VT[v].nw != 0) begin
        chk(wr_addr[0] == VT[v].fa && wr_data[0] == VT[v].fd, {vtag(v), " first write"},
            {wr_addr[0], wr_data[0]}, {VT[v].fa, VT[v].fd});
        chk(wr_addr[VT[v].nw-1] == VT[v].la && wr_data[VT[v].nw-1] == VT[v].ld, {vtag(v), " last write"},
            {wr_addr[VT[v].nw-1], wr_data[VT[v].nw-1]}, {VT[v].la, VT[v].ld});
      end
      chk(pwr_en == VT[v].pwr, {vtag(v), " power"}, 32'(pwr_en), 32'(VT[v].pwr));
      idle_check("R6 no fetch after terminate");
    end

    clear_logs();
    pulse(8'h10);
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk(mrd_addr[0] == 16'd4, "R2 vector address", 32'(mrd_addr[0]), 4);
    chk(mrd_addr[1] == 16'd50, "R2 R11 program start", 32'(mrd_addr[1]), 50);

    clear_logs();
    pulse(8'h04);
    repeat (4) @(posedge clk);
    pulse(8'h08);
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk(nwr == 2, "R3 latched count", 32'(nwr), 2);
    chk(wr_addr[0] == 16'h0301, "R3 running program first", 32'(wr_addr[0]), 32'h0301);
    chk(wr_addr[1] == 16'h0051, "R3 latched program second", 32'(wr_addr[1]), 32'h0051);

    slv_wait = 3;
    clear_logs();
    pulse(8'h02);
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk(nrd == 3 && nwr == 3, "R10 R9 stalled transfer", {nrd[15:0], nwr[15:0]}, {16'd3, 16'd3});
    chk(wr_data[2] == 16'h5B00 && wr_addr[2] == 16'h0200, "R10 stalled data", {wr_addr[2], wr_data[2]}, 32'h02005B00);

    clear_logs();
    pulse(8'h04);
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk(nwr == 1 && wr_data[0] == 16'h5900, "R7 R10 stalled read/write", 32'(wr_data[0]), 32'h5900);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule